// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This unit watches a port of GPIO input pins and turns their activity into a single interrupt request for the CPU. Each pin passes through a two-stage synchronizer. A per-pin detector then raises an event, and the event is latched into a sticky status bit. Each pin has its own enable mask bit. The interrupt line is high whenever a pending status bit has its mask bit set.

By default a pin reports any transition, rising or falling. Software can switch a pin to an extended detection mode. In that mode the pin reports either one edge direction or an active level, and its polarity is chosen by a separate set/clear pair. Every control field is written through a pair of registers: one sets bits and one clears them. Zero bits in a write leave the field unchanged. Reading the status register returns the pending events and clears them in the same access. A single dummy read therefore flushes stale events.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Writing to address 0 sets mask bits where the data is 1. Writing to address 1 clears mask bits where the data is 1. Zero data bits leave the mask unchanged. The mask reads back at addresses 0, 1 and 2.
- R2: Writing all ones to address 1 clears every mask bit in one access.
- R3: A pin event sets its status bit whatever its mask bit is. `irq_o` is high exactly when some status bit and its mask bit are both 1, so setting a mask bit over an already pending status raises `irq_o`.
- R4: A read of address 3 returns the status and clears it at the following clock edge. An event detected in that same cycle stays set.
- R5: With extended mode off for a pin (reset default), both a rising and a falling transition set its status bit.
- R6: Addresses 4 and 5 set and clear the per-pin extended-mode bit (readable at 4 and 5). With extended mode on and edge selected, only the edge matching the polarity bit sets status: rising when the polarity bit is 1, falling when it is 0.
- R7: Addresses 6 and 7 select level (bit 1) and edge (bit 0) per pin, readable at 6 and 7. In level mode the status bit is set on every cycle the active level is present, including the cycle right after a clearing read.
- R8: Addresses 8 and 9 select rising/high (bit 1) and falling/low (bit 0) polarity per pin, readable at 8 and 9.
- R9: After reset the mask, extended-mode, level-select, polarity and status registers are all zero, and `irq_o` is low.
- R10: A pin change driven before clock edge k appears in status after edge k+2. It is not visible after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Asynchronous GPIO pin levels |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that bus strobes and addresses are known after reset. They also assume that a read of status and a write to the mask pair never fall in the same cycle, since the bus carries one access at a time. The bench drives every bus access and pin change at the falling clock edge and issues one access per cycle. After each pin change it holds the pins stable long enough for the synchronizer and detector to settle before it reads status. This keeps the expected status a pure function of the old and new pin values and the mode configuration.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_IEN_SET = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 4'd1;
  localparam logic [ADDR_W-1:0] A_MASK    = 4'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd3;
  localparam logic [ADDR_W-1:0] A_XM_SET  = 4'd4;
  localparam logic [ADDR_W-1:0] A_XM_CLR  = 4'd5;
  localparam logic [ADDR_W-1:0] A_LVL_SEL = 4'd6;
  localparam logic [ADDR_W-1:0] A_EDG_SEL = 4'd7;
  localparam logic [ADDR_W-1:0] A_HI_SEL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_LO_SEL  = 4'd9;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_setclr.sv
module gpio_irq_setclr #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] xmode_i,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar n = 0; n < W; n++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[n] & ~prev_q[n];
    assign fall = ~lvl_i[n] & prev_q[n];
    always_comb begin
      if (!xmode_i[n])     evt_o[n] = rise | fall;
      else if (level_i[n]) evt_o[n] = pol_i[n] ? lvl_i[n] : ~lvl_i[n];
      else                 evt_o[n] = pol_i[n] ? rise : fall;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      pin_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  output logic              irq_o
);
  logic         wr, rd_status;
  logic [W-1:0] pin_s;
  logic [W-1:0] mask_q, xmode_q, level_q, pol_q, status_q, evt;

  assign wr        = bus_en_i & bus_we_i;
  assign rd_status = bus_en_i & ~bus_we_i & (bus_addr_i == A_STATUS);

  function automatic logic [W-1:0] wsel(input logic [ADDR_W-1:0] a);
    return (wr && bus_addr_i == a) ? bus_wdata_i : '0;
  endfunction

  gpio_irq_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  gpio_irq_setclr #(.W(W)) u_mask (
    .clk_i, .rst_ni, .set_i(wsel(A_IEN_SET)), .clr_i(wsel(A_IEN_CLR)), .q_o(mask_q)
  );
  gpio_irq_setclr #(.W(W)) u_xmode (
    .clk_i, .rst_ni, .set_i(wsel(A_XM_SET)), .clr_i(wsel(A_XM_CLR)), .q_o(xmode_q)
  );
  gpio_irq_setclr #(.W(W)) u_level (
    .clk_i, .rst_ni, .set_i(wsel(A_LVL_SEL)), .clr_i(wsel(A_EDG_SEL)), .q_o(level_q)
  );
  gpio_irq_setclr #(.W(W)) u_pol (
    .clk_i, .rst_ni, .set_i(wsel(A_HI_SEL)), .clr_i(wsel(A_LO_SEL)), .q_o(pol_q)
  );

  gpio_irq_detect #(.W(W)) u_det (
    .clk_i, .rst_ni, .lvl_i(pin_s), .xmode_i(xmode_q), .level_i(level_q),
    .pol_i(pol_q), .evt_o(evt)
  );

  // events arriving in the clearing cycle survive the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (rd_status ? '0 : status_q) | evt;
  end

  assign irq_o = |(status_q & mask_q);

  always_comb begin
    unique case (bus_addr_i)
      A_IEN_SET, A_IEN_CLR, A_MASK: bus_rdata_o = mask_q;
      A_STATUS:                     bus_rdata_o = status_q;
      A_XM_SET, A_XM_CLR:           bus_rdata_o = xmode_q;
      A_LVL_SEL, A_EDG_SEL:         bus_rdata_o = level_q;
      A_HI_SEL, A_LO_SEL:           bus_rdata_o = pol_q;
      default:                      bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [W-1:0]      bus_wdata_i,
  input logic [W-1:0]      mask_q,
  input logic [W-1:0]      status_q,
  input logic [W-1:0]      evt
);
  logic set_wr, clr_wr, st_rd;
  assign set_wr = bus_en_i && bus_we_i && bus_addr_i == A_IEN_SET;
  assign clr_wr = bus_en_i && bus_we_i && bus_addr_i == A_IEN_CLR;
  assign st_rd  = bus_en_i && !bus_we_i && bus_addr_i == A_STATUS;

  a_r1_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> (mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i));

  a_r1_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (mask_q & $past(bus_wdata_i)) == '0);

  a_r1_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_wr || clr_wr) |=> $stable(mask_q));

  a_r4_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd |=> status_q == $past(evt));

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_rd |=> (status_q & $past(status_q)) == $past(status_q));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .mask_q(mask_q),
  .status_q(status_q), .evt(evt)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  pin_i = '0;
  logic          bus_en_i = 1'b0, bus_we_i = 1'b0;
  logic [3:0]    bus_addr_i = '0;
  logic [W-1:0]  bus_wdata_i = '0;
  logic [W-1:0]  bus_rdata_o;
  logic          irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.W(W)) uut (
    .clk_i(clk), .rst_ni, .pin_i, .bus_en_i, .bus_we_i, .bus_addr_i,
    .bus_wdata_i, .bus_rdata_o, .irq_o
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_en_i = 0; bus_we_i = 0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_en_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] exp_status(
      input logic [W-1:0] o, input logic [W-1:0] n,
      input logic [W-1:0] xm, input logic [W-1:0] lv, input logic [W-1:0] pl);
    logic [W-1:0] any_c, edg, lvl;
    any_c = o ^ n;
    edg   = (~o & n & pl) | (o & ~n & ~pl);
    lvl   = ~(o ^ pl) | ~(n ^ pl);
    return (~xm & any_c) | (xm & ~lv & edg) | (xm & lv & lvl);
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rst_ni = 1;
    idle(2);

    // R9 reset state
    brd(4'd2, rd); check("R9 mask", rd, '0);
    brd(4'd3, rd); check("R9 status", rd, '0);
    brd(4'd4, rd); check("R9 xmode", rd, '0);
    brd(4'd6, rd); check("R9 level", rd, '0);
    brd(4'd8, rd); check("R9 pol", rd, '0);
    check("R9 irq", irq_o, '0);

    // R1 set/clear pair, zeros ignored
    bwr(4'd0, 32'h0000_00A5); brd(4'd2, rd); check("R1 set", rd, 32'hA5);
    bwr(4'd0, 32'h0);         brd(4'd0, rd); check("R1 set zero", rd, 32'hA5);
    bwr(4'd1, 32'h05);        brd(4'd1, rd); check("R1 clr", rd, 32'hA0);
    bwr(4'd1, 32'h0);         brd(4'd2, rd); check("R1 clr zero", rd, 32'hA0);
    // R2 all-ones disable
    bwr(4'd1, '1);            brd(4'd2, rd); check("R2 all off", rd, '0);

    // R10 latency, observed on irq_o with mask bit 5
    bwr(4'd0, 32'h20);
    @(negedge clk); pin_i[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); check("R10 not yet", irq_o, 1'b0);
    @(posedge clk);
    @(negedge clk); check("R10 after 3", irq_o, 1'b1);
    // R4 read-clear
    brd(4'd3, rd); check("R4 read", rd, 32'h20);
    brd(4'd3, rd); check("R4 cleared", rd, '0);
    check("R4 irq low", irq_o, 1'b0);
    // R5 falling edge in default mode
    pin_i[5] = 1'b0; idle(5);
    brd(4'd3, rd); check("R5 falling", rd, 32'h20);

    // R3 status independent of mask
    bwr(4'd1, '1);
    pin_i[7] = 1'b1; idle(5);
    check("R3 masked irq", irq_o, 1'b0);
    bwr(4'd0, 32'h80); idle(1);
    check("R3 unmask irq", irq_o, 1'b1);
    brd(4'd3, rd); check("R3 status", rd, 32'h80);
    check("R3 irq after read", irq_o, 1'b0);
    pin_i[7] = 1'b0; idle(5); brd(4'd3, rd);

    // R7 level-high on pin 3 keeps re-setting after reads
    bwr(4'd4, 32'h8); bwr(4'd6, 32'h8); bwr(4'd8, 32'h8);
    brd(4'd4, rd); check("R6 xmode rb", rd, 32'h8);
    brd(4'd7, rd); check("R7 level rb", rd, 32'h8);
    brd(4'd9, rd); check("R8 pol rb", rd, 32'h8);
    pin_i[3] = 1'b1; idle(5);
    brd(4'd3, rd); check("R7 level 1st", rd, 32'h8);
    brd(4'd3, rd); check("R7 level again", rd, 32'h8);
    pin_i[3] = 1'b0; idle(5);
    brd(4'd3, rd); check("R7 sticky", rd, 32'h8);
    brd(4'd3, rd); check("R7 inactive", rd, '0);

    // R6/R7/R8 random configurations and pin patterns
    for (int it = 0; it < 60; it++) begin
      logic [W-1:0] mk, xm, lv, pl, o, n, e;
      mk = $urandom; xm = $urandom; lv = $urandom; pl = $urandom;
      o = $urandom; n = (it % 4 == 0) ? o : $urandom;
      bwr(4'd0, mk); bwr(4'd1, ~mk);
      bwr(4'd4, xm); bwr(4'd5, ~xm);
      bwr(4'd6, lv); bwr(4'd7, ~lv);
      bwr(4'd8, pl); bwr(4'd9, ~pl);
      @(negedge clk); pin_i = o; idle(5);
      brd(4'd3, rd);
      pin_i = n; idle(5);
      e = exp_status(o, n, xm, lv, pl);
      check("R3 rand irq", irq_o, |(e & mk));
      brd(4'd3, rd); check("R6 R7 R8 rand status", rd, e);
      brd(4'd3, rd); check("R4 R7 rand reread", rd, xm & lv & ~(n ^ pl));
      brd(4'd2, rd); check("R1 rand mask", rd, mk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule